// File: doc/BRIEF.md
# Byte-Parallel CCITT CRC Engine

This block keeps a running 16-bit CCITT remainder and folds one whole byte into it on each clock edge. The update is a single combinational step, where a bit-serial generator would need eight shifts. It sits on an 8-bit data bus. A host writes bytes into it on that bus and reads the remainder back over the same lines, one byte at a time, through two active-low selects.

The generator is x^16 + x^12 + x^5 + 1, used in reflected form (0x8408). Bits within each byte are taken least-significant first. A synchronous active-low preset loads the all-ones start value. A byte-valid strobe marks the clocks that carry data. The read port drives zero and lowers its enable flag when neither select is asserted.

The default fold network first forms eight shared terms from the input byte and the low remainder byte, and derives all sixteen next bits from those terms. A parameter can instead select a generic network that unrolls the serial loop, for any polynomial of the same widths.

Top module: `crc_bytefold`

## Requirements
- R1: The remainder after a clock that carries a byte equals eight bit-serial steps applied to the old remainder. Each step takes the byte's bits from bit 0 upward: feedback = rem[0] xor bit, rem = rem >> 1, and rem ^= 0x8408 when the feedback is 1. Starting from 0xFFFF, the ASCII bytes "123456789" leave 0x6F91.
- R2: Every rising edge with `preset_n` high and `byte_vld` high folds exactly one byte, so consecutive bytes fold on consecutive cycles.
- R3: A rising edge with `preset_n` low loads 0xFFFF, whatever the values of `byte_vld` and `din`.
- R4: A rising edge with `preset_n` high and `byte_vld` low leaves the remainder unchanged.
- R5: While `sel_lo_n` is low, `bus_out` shows remainder bits 7:0 (bus line i carries remainder bit i) and `bus_oe` is 1.
- R6: While only `sel_hi_n` is low, `bus_out` shows remainder bits 15:8 (bus line i carries remainder bit i+8) and `bus_oe` is 1.
- R7: While both selects are low, the low byte wins: `bus_out` shows bits 7:0.
- R8: While both selects are high, `bus_out` is 0 and `bus_oe` is 0.
- R9: Take any block folded from preset. Then fold the ones' complement of its remainder, low byte first and high byte second. The remainder ends at 0xF0B8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| preset_n | input | 1 | Synchronous active-low load of 0xFFFF |
| byte_vld | input | 1 | High when `din` carries a byte to fold |
| din | input | 8 | Input byte, bit 0 processed first |
| sel_lo_n | input | 1 | Active-low select of remainder bits 7:0 |
| sel_hi_n | input | 1 | Active-low select of remainder bits 15:8 |
| bus_out | output | 8 | Selected remainder byte, or 0 when idle |
| bus_oe | output | 1 | High while a select is asserted |

## Verification
The bench builds two copies of the engine side by side. One uses `FOLD_STYLE` set to the factored eight-term network. The other uses the unrolled bitwise network with the same 0x8408 polynomial. Both are compared every cycle against the bench's own serial loop, so an error in the hand-factored equations shows up as a split between the two copies and the reference. All other parameters keep their defaults.

// File: rtl/crc_bytefold_pkg.sv
package crc_bytefold_pkg;

   // Variants of the byte-wide next-state network
   localparam int FOLD_FACTORED = 0;
   localparam int FOLD_BITWISE  = 1;

   // Reflected CCITT polynomial and its start value
   localparam logic [15:0] CCITT_REFL_POLY = 16'h8408;
   localparam logic [15:0] CCITT_INIT      = 16'hFFFF;

endpackage

// File: rtl/crc_fold_net.sv
module crc_fold_net #(
   parameter int          CRC_W      = 16,
   parameter int          BYTE_W     = 8,
   parameter logic [15:0] POLY       = crc_bytefold_pkg::CCITT_REFL_POLY,
   parameter int          FOLD_STYLE = crc_bytefold_pkg::FOLD_FACTORED
) (
   input  logic [CRC_W-1:0]  rem_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [CRC_W-1:0]  rem_o
);

   localparam int HALF = BYTE_W / 2;

   generate
      if (FOLD_STYLE == crc_bytefold_pkg::FOLD_FACTORED) begin : g_factored
         if (CRC_W != 16 || BYTE_W != 8 || POLY != 16'h8408) begin : g_bad
            $error("factored fold network needs 16-bit CCITT 0x8408 with 8-bit bytes");
         end
         logic [BYTE_W-1:0] mix;
         logic [BYTE_W-1:0] term;   // eight shared terms
         always_comb begin
            mix   = rem_i[BYTE_W-1:0] ^ byte_i;
            term  = mix ^ {mix[HALF-1:0], {HALF{1'b0}}};
            rem_o = {term, rem_i[CRC_W-1:BYTE_W]}
                  ^ {{(CRC_W-HALF){1'b0}}, term[BYTE_W-1:HALF]}
                  ^ {5'b0, term, 3'b0};
         end
      end else if (FOLD_STYLE == crc_bytefold_pkg::FOLD_BITWISE) begin : g_bitwise
         always_comb begin
            logic [CRC_W-1:0] acc;
            logic             fb;
            acc = rem_i;
            for (int i = 0; i < BYTE_W; i++) begin
               fb  = acc[0] ^ byte_i[i];
               acc = acc >> 1;
               if (fb) acc = acc ^ POLY[CRC_W-1:0];
            end
            rem_o = acc;
         end
      end else begin : g_bad_style
         $error("unknown FOLD_STYLE");
      end
   endgenerate

endmodule

// File: rtl/crc_rem_reg.sv
module crc_rem_reg #(
   parameter int             CRC_W = 16,
   parameter logic [CRC_W-1:0] INIT = '1
) (
   input  logic             clk,
   input  logic             preset_n,
   input  logic             load_en,
   input  logic [CRC_W-1:0] nxt_i,
   output logic [CRC_W-1:0] rem_q
);

   always_ff @(posedge clk) begin
      if (!preset_n)    rem_q <= INIT;    // preset beats a data update
      else if (load_en) rem_q <= nxt_i;
   end

endmodule

// File: rtl/crc_read_mux.sv
module crc_read_mux #(
   parameter int BYTE_W = 8
) (
   input  logic [2*BYTE_W-1:0] rem_i,
   input  logic                sel_lo_n,
   input  logic                sel_hi_n,
   output logic [BYTE_W-1:0]   bus_o,
   output logic                oe_o
);

   always_comb begin
      oe_o = !sel_lo_n || !sel_hi_n;
      if (!sel_lo_n)      bus_o = rem_i[BYTE_W-1:0];
      else if (!sel_hi_n) bus_o = rem_i[2*BYTE_W-1:BYTE_W];
      else                bus_o = '0;
   end

endmodule

// File: rtl/crc_bytefold.sv
module crc_bytefold #(
   parameter int          CRC_W      = 16,
   parameter int          BYTE_W     = 8,
   parameter logic [15:0] POLY       = crc_bytefold_pkg::CCITT_REFL_POLY,
   parameter logic [15:0] INIT       = crc_bytefold_pkg::CCITT_INIT,
   parameter int          FOLD_STYLE = crc_bytefold_pkg::FOLD_FACTORED
) (
   input  logic              clk,
   input  logic              preset_n,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] din,
   input  logic              sel_lo_n,
   input  logic              sel_hi_n,
   output logic [BYTE_W-1:0] bus_out,
   output logic              bus_oe
);

   localparam int RD_W = CRC_W / 2;

   generate
      if (CRC_W != 2 * BYTE_W) begin : g_width_chk
         $error("remainder must be exactly two bus bytes wide");
      end
      if (CRC_W > 16) begin : g_poly_chk
         $error("POLY and INIT parameters hold at most 16 bits");
      end
   endgenerate

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nxt;

   crc_fold_net #(
      .CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY), .FOLD_STYLE(FOLD_STYLE)
   ) u_fold (
      .rem_i(crc_q), .byte_i(din), .rem_o(crc_nxt)
   );

   crc_rem_reg #(
      .CRC_W(CRC_W), .INIT(INIT[CRC_W-1:0])
   ) u_rem (
      .clk(clk), .preset_n(preset_n), .load_en(byte_vld),
      .nxt_i(crc_nxt), .rem_q(crc_q)
   );

   crc_read_mux #(
      .BYTE_W(RD_W)
   ) u_rd (
      .rem_i(crc_q), .sel_lo_n(sel_lo_n), .sel_hi_n(sel_hi_n),
      .bus_o(bus_out), .oe_o(bus_oe)
   );

endmodule

// File: rtl/crc_bytefold_chk.sv
module crc_bytefold_chk #(
   parameter int          CRC_W  = 16,
   parameter int          BYTE_W = 8,
   parameter logic [15:0] POLY   = 16'h8408,
   parameter logic [15:0] INIT   = 16'hFFFF
) (
   input logic              clk,
   input logic              preset_n,
   input logic              byte_vld,
   input logic [BYTE_W-1:0] din,
   input logic              sel_lo_n,
   input logic              sel_hi_n,
   input logic [BYTE_W-1:0] bus_out,
   input logic              bus_oe,
   input logic [CRC_W-1:0]  crc
);

   function automatic logic [CRC_W-1:0] serial_fold(input logic [CRC_W-1:0] r,
                                                     input logic [BYTE_W-1:0] d);
      logic [CRC_W-1:0] a;
      logic             f;
      a = r;
      for (int i = 0; i < BYTE_W; i++) begin
         f = a[0] ^ d[i];
         a = a >> 1;
         if (f) a = a ^ POLY[CRC_W-1:0];
      end
      return a;
   endfunction

   logic started = 1'b0;
   always_ff @(posedge clk) started <= 1'b1;

   // R1
   fold_matches_serial_chk: assert property (@(posedge clk) disable iff (!started)
      preset_n && byte_vld |=> crc == serial_fold($past(crc), $past(din)));

   // R3
   preset_loads_init_chk: assert property (@(posedge clk) disable iff (!started)
      !preset_n |=> crc == INIT[CRC_W-1:0]);

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!started)
      preset_n && !byte_vld |=> $stable(crc));

   // R5
   low_read_chk: assert property (@(posedge clk) disable iff (!started)
      !sel_lo_n |-> bus_oe && bus_out == crc[BYTE_W-1:0]);

   // R6
   high_read_chk: assert property (@(posedge clk) disable iff (!started)
      sel_lo_n && !sel_hi_n |-> bus_oe && bus_out == crc[CRC_W-1:BYTE_W]);

   // R8
   idle_bus_chk: assert property (@(posedge clk) disable iff (!started)
      sel_lo_n && sel_hi_n |-> !bus_oe && bus_out == '0);

endmodule

bind crc_bytefold crc_bytefold_chk #(
   .CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY), .INIT(INIT)
) u_chk (
   .clk(clk), .preset_n(preset_n), .byte_vld(byte_vld), .din(din),
   .sel_lo_n(sel_lo_n), .sel_hi_n(sel_hi_n), .bus_out(bus_out),
   .bus_oe(bus_oe), .crc(crc_q)
);

// File: tb/crc_bytefold_bench.sv
module crc_bytefold_bench;

   logic       clk = 1'b0;
   logic       preset_n = 1'b1;
   logic       byte_vld = 1'b0;
   logic [7:0] din = '0;
   logic       sel_lo_n = 1'b1;
   logic       sel_hi_n = 1'b1;
   logic [7:0] bus_out, bus_out_b;
   logic       bus_oe, bus_oe_b;

   int   tests = 0;
   int   fails = 0;
   bit   done  = 1'b0;
   logic [15:0] ref_crc = 16'hFFFF;

   always #10 clk = ~clk;   // 50 MHz

   crc_bytefold u_crc_bytefold (
      .clk(clk), .preset_n(preset_n), .byte_vld(byte_vld), .din(din),
      .sel_lo_n(sel_lo_n), .sel_hi_n(sel_hi_n), .bus_out(bus_out), .bus_oe(bus_oe)
   );

   crc_bytefold #(.FOLD_STYLE(crc_bytefold_pkg::FOLD_BITWISE)) u_crc_bytefold_bw (
      .clk(clk), .preset_n(preset_n), .byte_vld(byte_vld), .din(din),
      .sel_lo_n(sel_lo_n), .sel_hi_n(sel_hi_n), .bus_out(bus_out_b), .bus_oe(bus_oe_b)
   );

   // Stimulus table: {preset_n, byte_vld, byte}
   localparam int NV = 16;
   localparam logic [9:0] VEC [NV] = '{
      10'b0_0_00000000, 10'b1_1_00110001, 10'b1_1_00110010, 10'b1_1_00110011,
      10'b1_1_00110100, 10'b1_1_00110101, 10'b1_1_00110110, 10'b1_1_00110111,
      10'b1_1_00111000, 10'b1_1_00111001, 10'b1_0_10101010, 10'b1_1_11111111,
      10'b0_1_01010101, 10'b1_1_10000000, 10'b1_0_00000001, 10'b1_1_00000001
   };

   function automatic logic [15:0] model_fold(input logic [15:0] r, input logic [7:0] d);
      logic [15:0] a = r;
      for (int i = 0; i < 8; i++) begin
         logic f = a[0] ^ d[i];
         a = a >> 1;
         if (f) a = a ^ 16'h8408;
      end
      return a;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic pre, input logic vld, input logic [7:0] d);
      @(negedge clk);
      preset_n = pre; byte_vld = vld; din = d;
      @(posedge clk);
      #1;
      if (!pre)     ref_crc = 16'hFFFF;
      else if (vld) ref_crc = model_fold(ref_crc, d);
      byte_vld = 1'b0; preset_n = 1'b1;
   endtask

   // Reads both remainder bytes through the selects of both copies.
   task automatic read_both(output logic [15:0] a, output logic [15:0] b);
      sel_lo_n = 1'b0; #1;
      a[7:0] = bus_out; b[7:0] = bus_out_b;
      sel_lo_n = 1'b1; sel_hi_n = 1'b0; #1;
      a[15:8] = bus_out; b[15:8] = bus_out_b;
      sel_hi_n = 1'b1; #1;
   endtask

   task automatic check_state(input string req);
      logic [15:0] a, b;
      read_both(a, b);
      check(req, a, ref_crc);
      check({req, " bitwise"}, b, ref_crc);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [15:0] a, b, blk;

      // R3: preset gives 0xFFFF
      step(1'b0, 1'b0, 8'h00);
      check_state("R3 preset state");

      // Table walk (R1, R2, R3, R4)
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][9], VEC[i][8], VEC[i][7:0]);
         check_state("R2 table step");
         if (i == 9) check("R1 check string", ref_crc, 16'h6F91);
      end

      // R4: hold with changing data
      blk = ref_crc;
      step(1'b1, 1'b0, 8'h5A);
      step(1'b1, 1'b0, 8'hC3);
      check_state("R4 hold");
      check("R4 hold value", ref_crc, blk);

      // R3: preset has priority over a valid byte
      step(1'b0, 1'b1, 8'h77);
      check_state("R3 preset priority");

      // R1: zero stream from preset
      for (int i = 0; i < 16; i++) begin
         step(1'b1, 1'b1, 8'h00);
         check_state("R1 zero stream");
      end

      // R9: random block then complement residue
      for (int k = 0; k < 4; k++) begin
         step(1'b0, 1'b0, 8'h00);
         for (int i = 0; i < 24; i++) step(1'b1, 1'b1, 8'($urandom));
         check_state("R1 random block");
         blk = ~ref_crc;
         step(1'b1, 1'b1, blk[7:0]);
         step(1'b1, 1'b1, blk[15:8]);
         read_both(a, b);
         check("R9 residue", a, 16'hF0B8);
         check("R9 residue bitwise", b, 16'hF0B8);
      end

      // R5 / R6 / R7 / R8 read port
      @(negedge clk);
      sel_lo_n = 1'b0; sel_hi_n = 1'b1; #1;
      check("R5 low byte", {7'b0, bus_oe, bus_out}, {7'b0, 1'b1, ref_crc[7:0]});
      sel_lo_n = 1'b1; sel_hi_n = 1'b0; #1;
      check("R6 high byte", {7'b0, bus_oe, bus_out}, {7'b0, 1'b1, ref_crc[15:8]});
      sel_lo_n = 1'b0; sel_hi_n = 1'b0; #1;
      check("R7 both selects", {7'b0, bus_oe, bus_out}, {7'b0, 1'b1, ref_crc[7:0]});
      sel_lo_n = 1'b1; sel_hi_n = 1'b1; #1;
      check("R8 idle bus", {7'b0, bus_oe, bus_out}, 16'h0000);

      finish_run();
   end

endmodule